// File: doc/BRIEF.md
# Multi-master bus arbiter

This block decides which of up to 16 masters owns a shared 32-bit on-chip peripheral bus. Each master drives a request line and a lock line and receives a grant line. A single-cycle "transfer done" pulse from the bus marks the end of the owner's transfer. The grant is re-decided only at that point, or while nobody holds the bus, or while the bus is parked.

Two selection policies are available. The dynamic policy, which is active after reset, grants the requester that has gone longest without completing a transfer. It keeps an ordered list of master indices and moves the owner to the tail when its transfer completes. The fixed policy walks a table of priority slots that software loads through a small write port. Slot 0 is the highest rank, and the table may be rewritten while the bus is running. A master that holds lock when its transfer completes keeps the bus. If parking is enabled, the last owner keeps its grant while no master requests. A flag reports a master that requests in fixed mode but has no slot in the table.

Top module: `mbus_arbiter`

## Requirements
- R1: After reset no grant is asserted, slot_err is low, the policy is dynamic, parking is off, the dynamic order is 0,1,...,N-1 (head first) and slot k holds master k.
- R2: In dynamic mode, a decision grants the requesting master that sits nearest the head of the order list.
- R3: When the active owner's transfer completes, that master moves to the tail of the order list and the masters behind it move up one place, before the decision in that same cycle. With all masters requesting, ownership therefore rotates 0,1,2,...
- R4: Config writes use cfg_addr 0 for control, where cfg_wdata bit 0 = 1 selects fixed mode and bit 1 = 1 enables parking. cfg_addr 1+k loads master index cfg_wdata[IW-1:0] into priority slot k. In fixed mode the requester found in the lowest-numbered slot wins, and completing a transfer does not change the ranking.
- R5: At most one grant is high in any cycle. An owner whose transfer is in progress keeps the grant until transfer done, whatever the other masters request.
- R6: A config write takes effect from the decision after the edge that stores it, including while a transfer is in progress.
- R7: An owner whose lock line is high in the cycle its transfer completes keeps the grant for another transfer.
- R8: With parking on, an owner that completes with no requester pending keeps its grant. Any request then re-decides ownership on the next edge. With parking off, the grant drops to none in that case.
- R9: In fixed mode a requesting master that appears in no slot is never granted, and slot_err is high in the cycle after such a request is seen.
- R10: With COMB_GRANT = 0 the grant appears one clock after the decision inputs. With COMB_GRANT = 1 the same grant appears combinationally in the cycle of the inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_req | input | N_MASTERS | Per-master bus request |
| bus_lock | input | N_MASTERS | Per-master hold-the-bus request |
| xfer_done | input | 1 | Current owner's transfer completes this cycle |
| cfg_we | input | 1 | Config write strobe |
| cfg_addr | input | IW+1 | Config address: 0 control, 1+k slot k |
| cfg_wdata | input | max(2,IW) | Config write data |
| bus_grant | output | N_MASTERS | One-hot (or zero) grant |
| slot_err | output | 1 | A fixed-mode requester has no slot |

## Verification
The hardest situation to reach is a dynamic-mode decision made from an order list that has been reshuffled many times, with partial request sets, lock hold-overs and parked owners handing off. Transfers that complete at the head of the list almost never produce it. The bench first drives a directed sequence that walks the list through a known series of moves, so the expected order can be tracked by hand. It then runs a long pseudo-random sweep that mixes requests, locks, completions and live table rewrites, including writes to unused addresses. Every cycle is compared against an arithmetic model of the rules. Both the registered and the combinational grant variants are checked in each cycle of the sweep.

// File: rtl/arb_pkg.sv
package arb_pkg;

  typedef enum logic {
    POL_DYNAMIC = 1'b0,
    POL_FIXED   = 1'b1
  } arb_policy_e;

  // Width of a master index, at least one bit.
  function automatic int idx_w(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

  // Width of config data: two control bits or one index, whichever is wider.
  function automatic int cfg_w(input int n);
    return (idx_w(n) < 2) ? 2 : idx_w(n);
  endfunction

endpackage

// File: rtl/arb_prio_table.sv
module arb_prio_table
  import arb_pkg::*;
#(
  parameter int N = 4
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           cfg_we,
  input  logic [idx_w(N):0]              cfg_addr,
  input  logic [cfg_w(N)-1:0]            cfg_wdata,
  output arb_policy_e                    policy,
  output logic                           park_en,
  output logic [N-1:0][idx_w(N)-1:0]     slot,
  output logic [N-1:0]                   covered
);
  localparam int IW = idx_w(N);
  localparam int AW = IW + 1;

  always_ff @(posedge clk) begin
    if (rst) begin
      policy  <= POL_DYNAMIC;
      park_en <= 1'b0;
      for (int i = 0; i < N; i++) slot[i] <= IW'(i);
    end else if (cfg_we) begin
      if (cfg_addr == '0) begin
        policy  <= arb_policy_e'(cfg_wdata[0]);
        park_en <= cfg_wdata[1];
      end
      for (int k = 0; k < N; k++)
        if (cfg_addr == AW'(k + 1)) slot[k] <= cfg_wdata[IW-1:0];
    end
  end

  // A master is covered when at least one slot names it.
  always_comb begin
    covered = '0;
    for (int m = 0; m < N; m++)
      for (int k = 0; k < N; k++)
        if (slot[k] == IW'(m)) covered[m] = 1'b1;
  end

endmodule

// File: rtl/arb_lru_order.sv
module arb_lru_order
  import arb_pkg::*;
#(
  parameter int N = 4
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       touch,
  input  logic [idx_w(N)-1:0]        touch_idx,
  output logic [N-1:0][idx_w(N)-1:0] order_nxt
);
  localparam int IW = idx_w(N);

  logic [N-1:0][IW-1:0] order_q;

  // Remove touch_idx from its place, close the gap, append it at the tail.
  always_comb begin
    logic seen;
    seen      = 1'b0;
    order_nxt = order_q;
    if (touch) begin
      for (int i = 0; i < N - 1; i++) begin
        if (order_q[i] == touch_idx) seen = 1'b1;
        if (seen) order_nxt[i] = order_q[i+1];
      end
      order_nxt[N-1] = touch_idx;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < N; i++) order_q[i] <= IW'(i);
    end else begin
      order_q <= order_nxt;
    end
  end

  logic [N-1:0] present;
  always_comb begin
    present = '0;
    for (int i = 0; i < N; i++)
      for (int m = 0; m < N; m++)
        if (order_q[i] == IW'(m)) present[m] = 1'b1;
  end

  // R3: the order list always holds every master exactly once
  a_r3_order_perm: assert property (@(posedge clk) disable iff (rst)
    $countones(present) == N);

  // R3: a completed owner sits at the tail afterwards
  a_r3_tail: assert property (@(posedge clk) disable iff (rst)
    touch |=> order_q[N-1] == $past(touch_idx));

endmodule

// File: rtl/arb_pick.sv
module arb_pick
  import arb_pkg::*;
#(
  parameter int N = 4
) (
  input  logic [N-1:0]               req,
  input  arb_policy_e                policy,
  input  logic [N-1:0][idx_w(N)-1:0] dyn_order,
  input  logic [N-1:0][idx_w(N)-1:0] slot,
  output logic                       found,
  output logic [idx_w(N)-1:0]        win
);
  localparam int IW = idx_w(N);

  logic [N-1:0][IW-1:0] rank;

  // The policy picks which ordered list is walked; both are head-first.
  generate
    for (genvar g = 0; g < N; g++) begin : g_rank
      assign rank[g] = (policy == POL_FIXED) ? slot[g] : dyn_order[g];
    end
  endgenerate

  // Walk tail to head so the entry nearest the head overrides.
  always_comb begin
    found = 1'b0;
    win   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[rank[i]]) begin
        found = 1'b1;
        win   = rank[i];
      end
    end
  end

endmodule

// File: rtl/mbus_arbiter.sv
module mbus_arbiter
  import arb_pkg::*;
#(
  parameter int N_MASTERS  = 4,
  parameter bit COMB_GRANT = 1'b0
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic [N_MASTERS-1:0]          bus_req,
  input  logic [N_MASTERS-1:0]          bus_lock,
  input  logic                          xfer_done,
  input  logic                          cfg_we,
  input  logic [idx_w(N_MASTERS):0]     cfg_addr,
  input  logic [cfg_w(N_MASTERS)-1:0]   cfg_wdata,
  output logic [N_MASTERS-1:0]          bus_grant,
  output logic                          slot_err
);
  localparam int N  = N_MASTERS;
  localparam int IW = idx_w(N);
  localparam logic [N-1:0] ONE = {{(N-1){1'b0}}, 1'b1};

  arb_policy_e          policy;
  logic                 park_en;
  logic [N-1:0][IW-1:0] slot;
  logic [N-1:0]         covered;
  logic [N-1:0][IW-1:0] order_nxt;
  logic                 win_found;
  logic [IW-1:0]        win_idx;

  // Ownership state
  logic          own_v;
  logic          parked;
  logic [IW-1:0] own_idx;
  logic          nx_v;
  logic          nx_park;
  logic [IW-1:0] nx_idx;
  logic          slot_err_q;

  logic active, touch, arb_open, keep_lock;
  assign active    = own_v && !parked;
  assign touch     = active && xfer_done;
  assign arb_open  = !own_v || parked || xfer_done;
  assign keep_lock = touch && bus_lock[own_idx];

  arb_prio_table #(.N(N)) u_table (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .policy(policy), .park_en(park_en),
    .slot(slot), .covered(covered)
  );

  arb_lru_order #(.N(N)) u_order (
    .clk(clk), .rst(rst), .touch(touch), .touch_idx(own_idx),
    .order_nxt(order_nxt)
  );

  arb_pick #(.N(N)) u_pick (
    .req(bus_req), .policy(policy), .dyn_order(order_nxt), .slot(slot),
    .found(win_found), .win(win_idx)
  );

  always_comb begin
    nx_v    = own_v;
    nx_idx  = own_idx;
    nx_park = parked;
    if (arb_open && !keep_lock) begin
      if (win_found) begin
        nx_v    = 1'b1;
        nx_idx  = win_idx;
        nx_park = 1'b0;
      end else if (park_en && own_v) begin
        nx_park = 1'b1;
      end else begin
        nx_v    = 1'b0;
        nx_park = 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      own_v      <= 1'b0;
      parked     <= 1'b0;
      own_idx    <= '0;
      slot_err_q <= 1'b0;
    end else begin
      own_v      <= nx_v;
      parked     <= nx_park;
      own_idx    <= nx_idx;
      slot_err_q <= (policy == POL_FIXED) && |(bus_req & ~covered);
    end
  end

  assign slot_err = slot_err_q;

  generate
    if (COMB_GRANT) begin : g_comb
      assign bus_grant = nx_v ? (ONE << nx_idx) : '0;
    end else begin : g_reg
      assign bus_grant = own_v ? (ONE << own_idx) : '0;
    end
  endgenerate

  // R5: never more than one grant
  a_r5_onehot: assert property (@(posedge clk) disable iff (rst)
    $onehot0(bus_grant));

  // R5: a transfer in progress keeps its owner
  a_r5_hold: assert property (@(posedge clk) disable iff (rst)
    active && !xfer_done |=> own_v && !parked && own_idx == $past(own_idx));

  // R7: lock held at completion keeps the owner
  a_r7_lock: assert property (@(posedge clk) disable iff (rst)
    active && xfer_done && bus_lock[own_idx] |=> active && own_idx == $past(own_idx));

  // R8: a parked owner stays parked while nobody requests
  a_r8_park: assert property (@(posedge clk) disable iff (rst)
    parked && park_en && bus_req == '0 |=> parked && $stable(own_idx));

  // R2: the selector only ever names a requesting master
  a_r2_win_req: assert property (@(posedge clk) disable iff (rst)
    win_found |-> bus_req[win_idx]);

  // R9: in fixed mode the selector never names an unslotted master
  a_r9_covered: assert property (@(posedge clk) disable iff (rst)
    win_found && policy == POL_FIXED |-> covered[win_idx]);

endmodule

// File: tb/sim_mbus_arbiter.sv
module sim_mbus_arbiter;
  localparam int N  = 4;
  localparam int IW = 2;
  localparam int AW = 3;
  localparam int CW = 2;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic          rst;
  logic [N-1:0]  req, lock;
  logic          done, cfg_we;
  logic [AW-1:0] cfg_addr;
  logic [CW-1:0] cfg_wdata;
  logic [N-1:0]  gnt0, gnt1;
  logic          err0, err1;

  mbus_arbiter #(.N_MASTERS(N), .COMB_GRANT(1'b0)) u0 (
    .clk(clk), .rst(rst), .bus_req(req), .bus_lock(lock), .xfer_done(done),
    .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .bus_grant(gnt0), .slot_err(err0)
  );

  mbus_arbiter #(.N_MASTERS(N), .COMB_GRANT(1'b1)) u1 (
    .clk(clk), .rst(rst), .bus_req(req), .bus_lock(lock), .xfer_done(done),
    .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .bus_grant(gnt1), .slot_err(err1)
  );

  int n_vec = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  // Arithmetic model of the rules
  logic          m_v, m_park, m_fixed, m_parken, m_err;
  logic [IW-1:0] m_own;
  logic [IW-1:0] m_lru [N];
  logic [IW-1:0] m_slot[N];

  function automatic logic [N-1:0] m_grant();
    return m_v ? (N'(1) << m_own) : '0;
  endfunction

  task automatic chk(input string tag, input logic [N-1:0] act, input logic [N-1:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%b exp=%b", tag, act, exp);
    end
  endtask

  task automatic model_reset();
    m_v = 0; m_park = 0; m_fixed = 0; m_parken = 0; m_err = 0; m_own = '0;
    for (int i = 0; i < N; i++) begin
      m_lru[i]  = IW'(i);
      m_slot[i] = IW'(i);
    end
  endtask

  task automatic model_step();
    logic [IW-1:0] l2[N];
    logic [IW-1:0] c, w;
    logic [N-1:0]  cov;
    logic          tch, fnd, e;
    int p;
    tch = m_v && !m_park && done;
    l2  = m_lru;
    if (tch) begin
      p = 0;
      for (int i = 0; i < N; i++) if (m_lru[i] == m_own) p = i;
      for (int i = 0; i < N - 1; i++) if (i >= p) l2[i] = m_lru[i+1];
      l2[N-1] = m_own;
    end
    cov = '0;
    for (int k = 0; k < N; k++) cov[m_slot[k]] = 1'b1;
    e = m_fixed && |(req & ~cov);
    fnd = 0; w = '0;
    for (int k = 0; k < N; k++) begin
      c = m_fixed ? m_slot[k] : l2[k];
      if (!fnd && req[c]) begin fnd = 1; w = c; end
    end
    if (!m_v || m_park || done) begin
      if (tch && lock[m_own]) begin
        m_park = 0;
      end else if (fnd) begin
        m_v = 1; m_own = w; m_park = 0;
      end else if (m_parken && m_v) begin
        m_park = 1;
      end else begin
        m_v = 0; m_park = 0;
      end
    end
    m_lru = l2;
    m_err = e;
    if (cfg_we) begin
      if (cfg_addr == 0) begin
        m_fixed  = cfg_wdata[0];
        m_parken = cfg_wdata[1];
      end else if (int'(cfg_addr) <= N) begin
        m_slot[int'(cfg_addr) - 1] = cfg_wdata[IW-1:0];
      end
    end
  endtask

  // One bus cycle: drive at negedge, check the combinational variant before
  // the edge and the registered variant after it.
  task automatic cyc(input logic [N-1:0] r, input logic [N-1:0] lk, input logic d,
                     input logic we, input logic [AW-1:0] a, input logic [CW-1:0] wd);
    @(negedge clk);
    req = r; lock = lk; done = d; cfg_we = we; cfg_addr = a; cfg_wdata = wd;
    #1;
    model_step();
    chk("R10 comb grant", gnt1, m_grant());
    @(posedge clk);
    #1;
    chk("R5 model grant", gnt0, m_grant());
    chk("R9 model slot_err", {3'b000, err0}, {3'b000, m_err});
  endtask

  task automatic go(input logic [N-1:0] r, input logic [N-1:0] lk, input logic d);
    cyc(r, lk, d, 1'b0, '0, '0);
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [CW-1:0] wd);
    cyc('0, '0, 1'b0, 1'b1, a, wd);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog act=running exp=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    logic [15:0] lf;
    rst = 1; req = '0; lock = '0; done = 0; cfg_we = 0; cfg_addr = '0; cfg_wdata = '0;
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 0;
    @(posedge clk); #1;
    chk("R1 reset grant", gnt0, '0);
    chk("R1 reset slot_err", {3'b000, err0}, '0);
    chk("R1 reset comb grant", gnt1, '0);

    // R2/R3: all requesting, rotation 0,1,2,3,0
    go(4'b1111, '0, 0); chk("R2 first grant", gnt0, 4'b0001);
    go(4'b1111, '0, 1); chk("R3 rotate to 1", gnt0, 4'b0010);
    go(4'b1111, '0, 1); chk("R3 rotate to 2", gnt0, 4'b0100);
    go(4'b1111, '0, 1); chk("R3 rotate to 3", gnt0, 4'b1000);
    go(4'b1111, '0, 1); chk("R3 rotate to 0", gnt0, 4'b0001);
    // R5: no completion, others requesting
    go(4'b1110, '0, 0); chk("R5 hold owner", gnt0, 4'b0001);
    // R8: park off, no requests at completion
    go(4'b0000, '0, 1); chk("R8 no park drop", gnt0, 4'b0000);
    // R2: order now 1,2,3,0 -> master 2 beats 0
    go(4'b0101, '0, 0); chk("R2 lru partial", gnt0, 4'b0100);
    go(4'b0101, '0, 1); chk("R2 lru next", gnt0, 4'b0001);
    go(4'b0000, '0, 1); chk("R2 idle", gnt0, 4'b0000);
    // R7: lock
    go(4'b1000, '0, 0); chk("R7 grant 3", gnt0, 4'b1000);
    go(4'b0111, 4'b1000, 1); chk("R7 lock keeps", gnt0, 4'b1000);
    go(4'b0111, 4'b0000, 1); chk("R7 release", gnt0, 4'b0010);
    go(4'b0000, '0, 1); chk("R7 idle", gnt0, 4'b0000);
    // R8: parking on
    wr(3'd0, 2'b10);
    go(4'b0001, '0, 0); chk("R8 grant 0", gnt0, 4'b0001);
    go(4'b0000, '0, 1); chk("R8 parked", gnt0, 4'b0001);
    go(4'b0000, '0, 0); chk("R8 still parked", gnt0, 4'b0001);
    go(4'b0100, '0, 0); chk("R8 handoff", gnt0, 4'b0100);
    go(4'b0000, '0, 1); chk("R8 parked on 2", gnt0, 4'b0100);
    wr(3'd0, 2'b00);    chk("R6 old park used", gnt0, 4'b0100);
    go(4'b0000, '0, 0); chk("R8 park off drops", gnt0, 4'b0000);
    // R4: fixed table 2,0,3,1
    wr(3'd1, 2'd2); wr(3'd2, 2'd0); wr(3'd3, 2'd3); wr(3'd4, 2'd1); wr(3'd0, 2'b01);
    go(4'b1011, '0, 0); chk("R4 fixed pick", gnt0, 4'b0001);
    go(4'b1011, '0, 1); chk("R4 no rotation", gnt0, 4'b0001);
    go(4'b1010, '0, 1); chk("R4 slot2", gnt0, 4'b1000);
    // R6: rewrite slot 0 while a transfer runs
    cyc(4'b1010, '0, 0, 1'b1, 3'd1, 2'd1); chk("R6 hold during write", gnt0, 4'b1000);
    go(4'b1010, '0, 1); chk("R6 new table", gnt0, 4'b0010);
    // R9: master 2 now has no slot
    go(4'b0100, '0, 1); chk("R9 never granted", gnt0, 4'b0000);
    chk("R9 flag", {3'b000, err0}, 4'b0001);
    go(4'b0100, '0, 0); chk("R9 still none", gnt0, 4'b0000);
    go(4'b0000, '0, 0); chk("R9 flag clears", {3'b000, err0}, 4'b0000);
    wr(3'd1, 2'd2);

    // Sweep: random requests, locks, completions and config writes
    lf = 16'hACE1;
    for (int t = 0; t < 4000; t++) begin
      logic [15:0] a, b;
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]}; a = lf;
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]}; b = lf;
      cyc(a[3:0], a[7:4] & a[11:8] & {4{a[12]}}, a[13] | a[14],
          b[3:0] == 4'd0, b[6:4], b[8:7]);
    end

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule